// File: doc/BRIEF.md
# GPIO Edge Detect Status Unit

This unit watches a bank of general-purpose input pins and turns chosen signal transitions into sticky status bits. Each pin can be set to record rising transitions, falling transitions, both, or neither. Software programs the two enable masks through a simple register write port. It reads the status mask back through a combinational read port. It acknowledges events by writing ones to the status register.

Each pin is resynchronized into the local clock domain before its edges are judged. Every pin in the low group gets a dedicated interrupt line that follows its own status bit. All pins above that group are merged into one shared interrupt line. That line stays high while any of their status bits is still set, so a handler can service those pins one at a time.

Top module: `gped_top`

## Requirements
- R1: After a synchronous active-low reset, the rising-enable, falling-enable and status registers read zero, and every interrupt output is low.
- R2: With a pin's rising enable set, a 0-to-1 transition on that pin sets its status bit. A 1-to-0 transition does not, unless the falling enable is also set.
- R3: With a pin's falling enable set, a 1-to-0 transition on that pin sets its status bit. A 0-to-1 transition does not, unless the rising enable is also set.
- R4: With both enables set, a pin records a transition in either direction.
- R5: With both enables cleared, transitions on a pin never set its status bit.
- R6: A write to the status register clears exactly the bits written as 1. Bits written as 0 keep their value. Such a write never sets a bit.
- R7: Writing all ones to the status register clears every pending bit.
- R8: Interrupt output k, for k from 0 to DIRECT_PINS-1 (0 to 10 by default), equals status bit k.
- R9: The shared interrupt output is the OR of status bits DIRECT_PINS to NUM_PINS-1 (11 to 27 by default). It stays high until the last of those bits is cleared.
- R10: When a new transition and a clearing write reach the same status bit on the same clock edge, the bit ends up set.
- R11: Address 0x0 holds the rising enables, address 0x4 holds the falling enables, and address 0x8 holds the status. Bit n of each register belongs to pin n. All three read back their current value. Writes to any other address change nothing, and reads from any other address return zero.
- R12: A pin change applied just before a rising clock edge is reflected in the status register after the third rising edge, counting that edge as the first. The status bit is still clear after the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous input pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write byte address |
| wr_data | input | NUM_PINS | Register write data |
| rd_addr | input | 4 | Register read byte address |
| rd_data | output | NUM_PINS | Read data for rd_addr, combinational |
| irq_direct | output | DIRECT_PINS | Per-pin interrupt lines for the low group |
| irq_shared | output | 1 | OR of status bits for the high group |

## Verification
The bench builds the unit with its default parameters: 28 pins, 11 direct lines and a two-stage synchronizer. This places pin 10 on the last direct line, pin 11 on the first shared one, and pin 27 on the top bit. All three boundary pins are driven. The default synchronizer depth fixes the three-edge latency. Because that latency is fixed, the bench can place a clearing write on the exact edge where a fresh transition lands.

// File: rtl/gped_pkg.sv
// Shared definitions for the GPIO edge detect status unit: register
// offsets, a register select type and the address decoder.
package gped_pkg;

    localparam int unsigned REG_ADDR_W = 4;

    localparam logic [REG_ADDR_W-1:0] OFF_RISE = 4'h0;
    localparam logic [REG_ADDR_W-1:0] OFF_FALL = 4'h4;
    localparam logic [REG_ADDR_W-1:0] OFF_STAT = 4'h8;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_RISE,
        SEL_FALL,
        SEL_STAT
    } reg_sel_e;

    // Map a byte address onto the register it selects.
    function automatic reg_sel_e decode_addr(input logic [REG_ADDR_W-1:0] addr);
        case (addr)
            OFF_RISE: return SEL_RISE;
            OFF_FALL: return SEL_FALL;
            OFF_STAT: return SEL_STAT;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gped_edge.sv
// Per-pin synchronizer and transition detector.
// Assumes pin_i is asynchronous to clk. Each pin passes through
// SYNC_STAGES flops, and the last stage is compared with its value one
// cycle earlier. rise_o and fall_o are single-cycle pulses. All stages
// reset to zero, so a pin held high through reset shows one rising
// pulse after release.
module gped_edge #(
    parameter int unsigned NUM_PINS    = 28,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] rise_o,
    output logic [NUM_PINS-1:0] fall_o
);

    logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];
    logic [NUM_PINS-1:0] prev_q;
    logic [NUM_PINS-1:0] cur_w;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the raw pins into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= pin_i;
            end
        end else begin : g_next
            // Shift the sample one stage deeper.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign cur_w = stage_q[SYNC_STAGES-1];

    // Keep the previous synchronized sample for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur_w;
    end

    // Flag transitions by comparing the current and previous samples.
    always_comb begin
        rise_o = cur_w & ~prev_q;
        fall_o = ~cur_w & prev_q;
    end

endmodule

// File: rtl/gped_regs.sv
// Enable registers, write decode and read multiplexer.
// Assumes at most one write per cycle. A status write is passed on as a
// clear strobe, and the write data serves as the clear mask. The read
// port is combinational.
module gped_regs
    import gped_pkg::*;
#(
    parameter int unsigned NUM_PINS = 28
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [NUM_PINS-1:0]   wr_data,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    input  logic [NUM_PINS-1:0]   status_i,
    output logic [NUM_PINS-1:0]   rise_en_o,
    output logic [NUM_PINS-1:0]   fall_en_o,
    output logic [NUM_PINS-1:0]   rd_data_o,
    output logic                  clr_stb_o
);

    reg_sel_e wr_sel;
    reg_sel_e rd_sel;

    assign wr_sel = decode_addr(wr_addr);
    assign rd_sel = decode_addr(rd_addr);

    // Hold the rising-edge enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rise_en_o <= '0;
        else if (wr_en && wr_sel == SEL_RISE) rise_en_o <= wr_data;
    end

    // Hold the falling-edge enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)                          fall_en_o <= '0;
        else if (wr_en && wr_sel == SEL_FALL) fall_en_o <= wr_data;
    end

    assign clr_stb_o = wr_en && (wr_sel == SEL_STAT);

    // Select read data by address; unmapped addresses return zero.
    always_comb begin
        case (rd_sel)
            SEL_RISE: rd_data_o = rise_en_o;
            SEL_FALL: rd_data_o = fall_en_o;
            SEL_STAT: rd_data_o = status_i;
            default:  rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/gped_status.sv
// Sticky status register with write-one-to-clear.
// Assumes hit_i holds this cycle's enabled transitions. A bit that is hit
// and cleared on the same edge stays set.
module gped_status #(
    parameter int unsigned NUM_PINS = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] hit_i,
    input  logic                clr_stb_i,
    input  logic [NUM_PINS-1:0] clr_mask_i,
    output logic [NUM_PINS-1:0] status_o
);

    logic [NUM_PINS-1:0] clr_w;

    assign clr_w = {NUM_PINS{clr_stb_i}} & clr_mask_i;

    // Clear the written ones first, then OR in new hits so a hit wins.
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= (status_o & ~clr_w) | hit_i;
    end

endmodule

// File: rtl/gped_top.sv
// GPIO edge detect status unit, top level.
// Assumes DIRECT_PINS <= NUM_PINS. Pins below DIRECT_PINS each drive a
// dedicated interrupt line. All higher pins share one OR-ed line.
module gped_top
    import gped_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 28,
    parameter int unsigned DIRECT_PINS = 11,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PINS-1:0]    pin_i,
    input  logic                   wr_en,
    input  logic [REG_ADDR_W-1:0]  wr_addr,
    input  logic [NUM_PINS-1:0]    wr_data,
    input  logic [REG_ADDR_W-1:0]  rd_addr,
    output logic [NUM_PINS-1:0]    rd_data,
    output logic [DIRECT_PINS-1:0] irq_direct,
    output logic                   irq_shared
);

    localparam int unsigned SHARED_PINS = NUM_PINS - DIRECT_PINS;

    logic [NUM_PINS-1:0] rise_ev_w;
    logic [NUM_PINS-1:0] fall_ev_w;
    logic [NUM_PINS-1:0] rise_en_w;
    logic [NUM_PINS-1:0] fall_en_w;
    logic [NUM_PINS-1:0] hit_w;
    logic [NUM_PINS-1:0] status_w;
    logic                clr_stb_w;

    gped_edge #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .rise_o (rise_ev_w),
        .fall_o (fall_ev_w)
    );

    gped_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .status_i  (status_w),
        .rise_en_o (rise_en_w),
        .fall_en_o (fall_en_w),
        .rd_data_o (rd_data),
        .clr_stb_o (clr_stb_w)
    );

    // Keep only the transitions whose polarity is enabled.
    assign hit_w = (rise_ev_w & rise_en_w) | (fall_ev_w & fall_en_w);

    gped_status #(.NUM_PINS(NUM_PINS)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit_w),
        .clr_stb_i  (clr_stb_w),
        .clr_mask_i (wr_data),
        .status_o   (status_w)
    );

    assign irq_direct = status_w[DIRECT_PINS-1:0];

    if (SHARED_PINS > 0) begin : g_shared
        assign irq_shared = |status_w[NUM_PINS-1:DIRECT_PINS];
    end else begin : g_no_shared
        assign irq_shared = 1'b0;
    end

endmodule

// File: rtl/gped_chk.sv
// Assertion checker for gped_top. It is bound to the top level and
// observes the ports together with the enable and status registers.
module gped_chk
    import gped_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 28,
    parameter int unsigned DIRECT_PINS = 11
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [REG_ADDR_W-1:0]  wr_addr,
    input logic [NUM_PINS-1:0]    wr_data,
    input logic [REG_ADDR_W-1:0]  rd_addr,
    input logic [NUM_PINS-1:0]    rd_data,
    input logic [DIRECT_PINS-1:0] irq_direct,
    input logic                   irq_shared,
    input logic [NUM_PINS-1:0]    rise_en,
    input logic [NUM_PINS-1:0]    fall_en,
    input logic [NUM_PINS-1:0]    status
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && rise_en == '0 && fall_en == '0));

    // R11
    rise_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFF_RISE) |=> (rise_en == $past(wr_data)));

    // R11
    fall_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFF_FALL) |=> (fall_en == $past(wr_data)));

    // R5
    enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status & ~$past(status) & ~($past(rise_en) | $past(fall_en))) == '0));

    // R6
    clear_only_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(status) & ~status
                   & ~({NUM_PINS{$past(wr_en) && $past(wr_addr) == OFF_STAT}} & $past(wr_data))) == '0));

    // R8
    direct_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == OFF_STAT) |-> (irq_direct == rd_data[DIRECT_PINS-1:0]));

    // R9
    shared_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == OFF_STAT) |-> (irq_shared == (|rd_data[NUM_PINS-1:DIRECT_PINS])));

endmodule

bind gped_top gped_chk #(.NUM_PINS(NUM_PINS), .DIRECT_PINS(DIRECT_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .irq_direct (irq_direct),
    .irq_shared (irq_shared),
    .rise_en    (rise_en_w),
    .fall_en    (fall_en_w),
    .status     (status_w)
);

// File: tb/gped_top_bench.sv
// Directed bench for gped_top: one task per scenario, each checking its results.
module gped_top_bench;

    localparam int unsigned NP = 28;
    localparam int unsigned ND = 11;
    localparam logic [3:0] A_RISE = 4'h0;
    localparam logic [3:0] A_FALL = 4'h4;
    localparam logic [3:0] A_STAT = 4'h8;
    localparam logic [NP-1:0] ALL1 = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [NP-1:0] wr_data = '0;
    logic [3:0]    rd_addr = '0;
    logic [NP-1:0] rd_data;
    logic [ND-1:0] irq_direct;
    logic          irq_shared;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gped_top u_gped_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pins),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .irq_direct (irq_direct),
        .irq_shared (irq_shared)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [NP-1:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic drive(input logic [NP-1:0] v);
        @(negedge clk);
        pins = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic quiet();
        wr(A_RISE, '0);
        wr(A_FALL, '0);
        drive('0);
        wr(A_STAT, ALL1);
    endtask

    task automatic t_reset();
        logic [NP-1:0] d;
        rd(A_RISE, d); chk("R1 rise reg", 32'(d), 0);
        rd(A_FALL, d); chk("R1 fall reg", 32'(d), 0);
        rd(A_STAT, d); chk("R1 status", 32'(d), 0);
        chk("R1 irq_direct", 32'(irq_direct), 0);
        chk("R1 irq_shared", 32'(irq_shared), 0);
    endtask

    task automatic t_rising();
        logic [NP-1:0] d;
        quiet();
        wr(A_RISE, ALL1);
        drive(28'h0100008);
        rd(A_STAT, d); chk("R2 rise recorded", 32'(d), 32'h0100008);
        wr(A_STAT, ALL1);
        drive('0);
        rd(A_STAT, d); chk("R2 fall ignored", 32'(d), 0);
    endtask

    task automatic t_falling();
        logic [NP-1:0] d;
        quiet();
        wr(A_FALL, ALL1);
        drive(28'h8000201);
        rd(A_STAT, d); chk("R3 rise ignored", 32'(d), 0);
        drive('0);
        rd(A_STAT, d); chk("R3 fall recorded", 32'(d), 32'h8000201);
    endtask

    task automatic t_both();
        logic [NP-1:0] d;
        quiet();
        wr(A_RISE, 28'h20);
        wr(A_FALL, 28'h20);
        drive(28'h20);
        rd(A_STAT, d); chk("R4 rise side", 32'(d), 32'h20);
        wr(A_STAT, ALL1);
        drive('0);
        rd(A_STAT, d); chk("R4 fall side", 32'(d), 32'h20);
    endtask

    task automatic t_none();
        logic [NP-1:0] d;
        quiet();
        drive(ALL1);
        drive('0);
        rd(A_STAT, d); chk("R5 no record", 32'(d), 0);
        chk("R5 irq_direct quiet", 32'(irq_direct), 0);
        chk("R5 irq_shared quiet", 32'(irq_shared), 0);
    endtask

    task automatic t_w1c();
        logic [NP-1:0] d;
        quiet();
        wr(A_RISE, ALL1);
        drive(28'h0F0F00F);
        wr(A_STAT, 28'h000F005);
        rd(A_STAT, d); chk("R6 partial clear", 32'(d), 32'h0F0000A);
        wr(A_STAT, 28'h0000000);
        rd(A_STAT, d); chk("R6 zero write", 32'(d), 32'h0F0000A);
        wr(A_STAT, ALL1);
        rd(A_STAT, d); chk("R7 clear all", 32'(d), 0);
    endtask

    task automatic t_direct();
        quiet();
        wr(A_RISE, ALL1);
        drive(28'h401);
        chk("R8 direct lines", 32'(irq_direct), 32'h401);
        chk("R9 shared low for direct pins", 32'(irq_shared), 0);
        wr(A_STAT, 28'h1);
        chk("R8 direct after clear", 32'(irq_direct), 32'h400);
    endtask

    task automatic t_shared();
        quiet();
        wr(A_RISE, ALL1);
        drive(28'h800);
        chk("R9 pin 11 shared", 32'(irq_shared), 1);
        chk("R8 direct low for pin 11", 32'(irq_direct), 0);
        drive(28'h8000800);
        wr(A_STAT, 28'h800);
        chk("R9 held by pin 27", 32'(irq_shared), 1);
        wr(A_STAT, 28'h8000000);
        chk("R9 released", 32'(irq_shared), 0);
    endtask

    task automatic t_collision();
        logic [NP-1:0] d;
        quiet();
        wr(A_RISE, ALL1);
        drive(28'h2);
        @(negedge clk);
        pins = 28'h6;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_STAT; wr_data = 28'h6;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        rd(A_STAT, d); chk("R10 edge beats clear", 32'(d), 32'h4);
    endtask

    task automatic t_latency();
        logic [NP-1:0] d;
        quiet();
        wr(A_RISE, ALL1);
        @(negedge clk);
        pins = 28'h100;
        @(posedge clk);
        @(posedge clk);
        rd(A_STAT, d); chk("R12 clear after second edge", 32'(d), 0);
        @(posedge clk);
        rd(A_STAT, d); chk("R12 set after third edge", 32'(d), 32'h100);
    endtask

    task automatic t_map();
        logic [NP-1:0] d;
        quiet();
        wr(A_RISE, 28'hAAAAAAA);
        wr(A_FALL, 28'h5555555);
        rd(A_RISE, d); chk("R11 rise at 0x0", 32'(d), 32'hAAAAAAA);
        rd(A_FALL, d); chk("R11 fall at 0x4", 32'(d), 32'h5555555);
        wr(4'hC, ALL1);
        wr(4'h2, '0);
        rd(A_RISE, d); chk("R11 rise kept", 32'(d), 32'hAAAAAAA);
        rd(A_FALL, d); chk("R11 fall kept", 32'(d), 32'h5555555);
        rd(4'hC, d); chk("R11 unmapped reads zero", 32'(d), 0);
        wr(A_STAT, ALL1);
        rd(A_STAT, d); chk("R6 write never sets", 32'(d), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rising();
        t_falling();
        t_both();
        t_none();
        t_w1c();
        t_direct();
        t_shared();
        t_collision();
        t_latency();
        t_map();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule